// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a 64-bit-wide synchronous static memory with a built-in burst address sequencer, meant to sit behind a cache or processor port in a larger design. Every control, address and data input is captured on the rising clock edge. Read data leaves through an output register, so a word appears one clock after its address was taken. The external three-state data bus is split into a write-data input, a read-data output and a drive-enable output. The surrounding logic builds the pad or bus multiplexer from those three signals.

A burst starts on either of two address strobes. The processor strobe always starts a read and is ignored while the primary chip enable is inactive. The controller strobe starts a read or a write, depending on the write controls. The low two address bits then step through a four-word group, in either linear or interleaved order, each time the advance input is asserted. Writes can cover all eight byte lanes through a global write override, or chosen lanes through a byte-write enable together with one enable per lane. A sleep input quiets the block while keeping the stored data. After sleep is released, a short lockout window follows; a strobe that arrives inside that window is reported on an error flag.

Top module: `burst_sram`

## Requirements
- R1: After reset, `dout_en` and `proto_err` are both 0. The outputs do not drive until a read has completed.
- R2: When `strb_proc_n` is low and `ce_n` is low, a read of `addr` starts at that edge, whatever the write controls are, and no byte is written. The word appears on `dout`, with `dout_en`=1, after that same edge.
- R3: When `ce_n` is high, `strb_proc_n` is ignored. If a burst is active, it carries on at its current address. If no burst is active, nothing is driven.
- R4: When `strb_ctrl_n` is low, `strb_proc_n` is not taking effect, and all chip enables are valid, a burst starts at `addr`. The burst writes if the write controls request any lane and reads otherwise. If `ce_n` is high at that edge, the block deselects and `dout_en` is 0 after the edge.
- R5: The secondary enables must be `ce_hi`=1 and `ce_lo_n`=0 on a strobe edge, or the block deselects and does not write. On edges without a strobe, the secondary enables are ignored.
- R6: When `gwe_n` is low, all eight lanes are written, whatever `bwe_n` and `lane_we_n` are.
- R7: When `gwe_n` is high and `bwe_n` is low, lane n is written only if `lane_we_n[n]` is low. Lane n is bits 8n+7:8n, and lane 0 holds bits 7:0. When `gwe_n` and `bwe_n` are both high, or all lane enables are high, the cycle is a read.
- R8: A burst holds its start address in the upper bits. Each edge with `adv_n` low moves the low two bits to base+k mod 4 when `seq_linear`=1, or to base XOR k when `seq_linear`=0, where k counts the advances so far. An edge with `adv_n` high repeats the current address.
- R9: An edge without a strobe that has write controls writes during an active burst. With `adv_n` high it writes the current address, which covers a write following a processor-strobe start. With `adv_n` low it writes the advanced address, using data taken at that same edge.
- R10: `oe_n` high forces `dout_en` to 0 at once, without waiting for a clock edge.
- R11: While `sleep` is high, `dout_en` is 0, no access takes place, and the stored words keep their values.
- R12: On the two edges after `sleep` falls, both strobes are ignored. `proto_err` is 1 for the cycle after each such edge that saw a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address, taken on a strobe |
| strb_proc_n | input | 1 | Processor address strobe, active low, read only |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high, checked on strobes |
| ce_lo_n | input | 1 | Secondary chip enable, active low, checked on strobes |
| gwe_n | input | 1 | Global write, active low, writes every lane |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| seq_linear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| din | input | DW | Write data |
| dout | output | DW | Registered read data |
| dout_en | output | 1 | Drive enable for the read data |
| proto_err | output | 1 | A strobe was seen inside the post-sleep lockout |

## Verification
The hardest state to reach from the ports is the lockout window just after `sleep` falls. In that window a strobe must be dropped silently, and the write it carries must not reach the array. The stimulus holds a controller write strobe, with junk data, across the two edges that follow the release. It checks `proto_err` after each of those edges and checks that it clears on the third. It then reads the target word through a fresh processor strobe, which shows that the word kept its value through the sleep and through the blocked writes.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int REC_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb_proc_n,
  input  logic             strb_ctrl_n,
  input  logic             adv_n,
  input  logic             ce_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             sleep,
  output op_e              op,
  output logic             load,
  output logic             step,
  output logic [LANES-1:0] lane_en,
  output logic             proto_err
);
  localparam int REC_W = $clog2(REC_CYC + 1);

  logic [REC_W-1:0] rec_q, rec_d;
  logic             active_q, active_d;
  logic             err_q, err_d;
  logic             rec_on, proc_go, ctrl_go, sec_ok;
  logic [LANES-1:0] lane_req;

  assign rec_on  = (rec_q != '0);
  assign proc_go = !strb_proc_n && !ce_n;
  assign ctrl_go = !strb_ctrl_n;
  assign sec_ok  = ce_hi && !ce_lo_n;

  always_comb begin
    if (!gwe_n)      lane_req = '1;
    else if (!bwe_n) lane_req = ~lane_we_n;
    else             lane_req = '0;
  end

  always_comb begin
    op       = OP_NONE;
    load     = 1'b0;
    step     = 1'b0;
    active_d = active_q;
    if (sleep || rec_on) begin
      active_d = 1'b0;
    end else if (proc_go) begin
      if (sec_ok) begin
        load     = 1'b1;
        op       = OP_READ;
        active_d = 1'b1;
      end else begin
        active_d = 1'b0;
      end
    end else if (ctrl_go) begin
      if (!ce_n && sec_ok) begin
        load     = 1'b1;
        op       = (|lane_req) ? OP_WRITE : OP_READ;
        active_d = 1'b1;
      end else begin
        active_d = 1'b0;
      end
    end else if (active_q) begin
      step = !adv_n;
      op   = (|lane_req) ? OP_WRITE : OP_READ;
    end
  end

  assign lane_en = (op == OP_WRITE) ? lane_req : '0;

  always_comb begin
    if (sleep)       rec_d = REC_W'(REC_CYC);
    else if (rec_on) rec_d = rec_q - 1'b1;
    else             rec_d = '0;
    err_d = rec_on && !sleep && (!strb_proc_n || !strb_ctrl_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q    <= '0;
      active_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rec_q    <= rec_d;
      active_q <= active_d;
      err_q    <= err_d;
    end
  end

  assign proto_err = err_q;

  AST_RECOVERY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_on |-> (op == OP_NONE && lane_en == '0));  // R12

  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE && !gwe_n) |-> (&lane_en));  // R6
endmodule

// File: rtl/bsram_burst.sv
module bsram_burst #(
  parameter int AW         = 6,
  parameter int BURST_BITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          linear,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  localparam int BB = BURST_BITS;

  logic [AW-1:0] base_q, base_d, src;
  logic [BB-1:0] cnt_q, cnt_d, low;

  always_comb begin
    base_d = load ? addr_in : base_q;
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
    src = base_d;
    low = linear ? (src[BB-1:0] + cnt_d) : (src[BB-1:0] ^ cnt_d);
    addr_out = {src[AW-1:BB], low};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (load)         base_q <= base_d;
      if (load || step) cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rvld
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_en[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)      rd_q      <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvld <= 1'b0;
    else        rvld <= rd_en;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int LANES      = 8,
  parameter int LANE_W     = 8,
  parameter int REC_CYC    = 2,
  parameter int BURST_BITS = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             strb_proc_n,
  input  logic             strb_ctrl_n,
  input  logic             adv_n,
  input  logic             ce_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             gwe_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic             seq_linear,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_en,
  output logic             proto_err
);
  logic [1:0]       rst_sync;
  logic             rst_core_n;
  op_e              op;
  logic             load, step, rvld;
  logic [LANES-1:0] lane_en;
  logic [AW-1:0]    acc_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  bsram_ctrl #(.LANES(LANES), .REC_CYC(REC_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
    .ce_n(ce_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n), .sleep(sleep),
    .op(op), .load(load), .step(step), .lane_en(lane_en), .proto_err(proto_err)
  );

  bsram_burst #(.AW(AW), .BURST_BITS(BURST_BITS)) u_burst (
    .clk(clk), .rst_n(rst_core_n), .load(load), .step(step),
    .linear(seq_linear), .addr_in(addr), .addr_out(acc_addr)
  );

  bsram_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_core_n), .addr(acc_addr), .lane_en(lane_en),
    .rd_en(op == OP_READ), .wdata(din), .rdata(dout), .rvld(rvld)
  );

  assign dout_en = rvld && !oe_n && !sleep;

  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n)
    sleep |-> !dout_en);  // R11

  AST_PROC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!strb_proc_n && !ce_n) |-> (lane_en == '0));  // R2

  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!strb_ctrl_n && strb_proc_n && ce_n && !sleep) |=> !dout_en);  // R4

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op != OP_NONE && !load && !step) |-> (acc_addr == $past(acc_addr)));  // R8

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (!rst_core_n)
    (op != OP_NONE && !load && step) |->
      (acc_addr[AW-1:BURST_BITS] == $past(acc_addr[AW-1:BURST_BITS]) &&
       acc_addr[BURST_BITS-1:0] != $past(acc_addr[BURST_BITS-1:0])));  // R8
endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic        strb_proc_n, strb_ctrl_n, adv_n, ce_n, ce_hi, ce_lo_n;
  logic        gwe_n, bwe_n, oe_n, sleep, seq_linear;
  logic [7:0]  lane_we_n;
  logic [63:0] din, dout;
  logic        dout_en, proto_err;

  logic [63:0] mdl [64];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_sram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strb_proc_n(strb_proc_n),
    .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n), .ce_n(ce_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_we_n(lane_we_n),
    .oe_n(oe_n), .sleep(sleep), .seq_linear(seq_linear), .din(din),
    .dout(dout), .dout_en(dout_en), .proto_err(proto_err)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_in();
    strb_proc_n = 1; strb_ctrl_n = 1; adv_n = 1;
    ce_n = 0; ce_hi = 1; ce_lo_n = 0;
    gwe_n = 1; bwe_n = 1; lane_we_n = 8'hFF; oe_n = 0;
  endtask

  task automatic mdl_wr(logic [5:0] a, logic [63:0] d, logic g_n, logic b_n, logic [7:0] l_n);
    for (int i = 0; i < 8; i++)
      if (!g_n || (!b_n && !l_n[i])) mdl[a][8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic ctrl_write(logic [5:0] a, logic [63:0] d, logic g_n, logic b_n, logic [7:0] l_n);
    addr = a; din = d; gwe_n = g_n; bwe_n = b_n; lane_we_n = l_n; strb_ctrl_n = 0;
    tick();
    mdl_wr(a, d, g_n, b_n, l_n);
    idle_in();
  endtask

  task automatic proc_read(string req, logic [5:0] a);
    addr = a; strb_proc_n = 0; gwe_n = 0; din = ~mdl[a];
    tick();
    chk(req, {63'd0, dout_en}, 64'd1);
    chk(req, dout, mdl[a]);
    idle_in();
  endtask

  task automatic t_reset();
    chk("R1 dout_en", {63'd0, dout_en}, 64'd0);
    chk("R1 proto_err", {63'd0, proto_err}, 64'd0);
  endtask

  task automatic t_writes();
    ctrl_write(6'd5, 64'h1122_3344_5566_7788, 1'b0, 1'b1, 8'hFF);
    proc_read("R6", 6'd5);
    ctrl_write(6'd5, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, 1'b0, 8'hFB);
    proc_read("R7 lane2", 6'd5);
    chk("R7 value", mdl[5], 64'h1122_3344_55AA_7788);
    addr = 6'd5; din = 64'hFFFF_FFFF_FFFF_FFFF; bwe_n = 1; lane_we_n = 8'h00; strb_ctrl_n = 0;
    tick();
    chk("R7 read", dout, mdl[5]);
    chk("R4 read", {63'd0, dout_en}, 64'd1);
    idle_in();
  endtask

  task automatic t_proc_then_write();
    ctrl_write(6'd9, 64'h0, 1'b0, 1'b1, 8'hFF);
    proc_read("R2", 6'd9);
    gwe_n = 0; din = 64'hCAFE_F00D_1234_5678;
    tick();
    mdl_wr(6'd9, din, 1'b0, 1'b1, 8'hFF);
    idle_in();
    proc_read("R9 suspend write", 6'd9);
  endtask

  task automatic t_bursts();
    for (int k = 0; k < 4; k++)
      ctrl_write(6'(16 + k), 64'h5000 + 64'(k), 1'b0, 1'b1, 8'hFF);
    seq_linear = 1;
    addr = 6'h12; strb_ctrl_n = 0;
    tick(); chk("R8 lin0", dout, mdl[6'h12]);
    idle_in(); adv_n = 0;
    tick(); chk("R8 lin1", dout, mdl[6'h13]);
    tick(); chk("R8 lin2 wrap", dout, mdl[6'h10]);
    adv_n = 1;
    tick(); chk("R8 suspend", dout, mdl[6'h10]);
    adv_n = 0;
    tick(); chk("R8 lin3", dout, mdl[6'h11]);
    idle_in();
    seq_linear = 0;
    addr = 6'h11; strb_ctrl_n = 0;
    tick(); chk("R8 il0", dout, mdl[6'h11]);
    idle_in(); adv_n = 0;
    tick(); chk("R8 il1", dout, mdl[6'h10]);
    tick(); chk("R8 il2", dout, mdl[6'h13]);
    tick(); chk("R8 il3", dout, mdl[6'h12]);
    idle_in();
    seq_linear = 1;
    ctrl_write(6'h20, 64'hA0A0, 1'b0, 1'b1, 8'hFF);
    adv_n = 0; gwe_n = 0; din = 64'hB1B1;
    tick();
    mdl_wr(6'h21, 64'hB1B1, 1'b0, 1'b1, 8'hFF);
    idle_in();
    proc_read("R9 burst write base", 6'h20);
    proc_read("R9 burst write next", 6'h21);
  endtask

  task automatic t_enables();
    addr = 6'h12; strb_ctrl_n = 0;
    tick(); idle_in();
    strb_proc_n = 0; ce_n = 1; addr = 6'h10;
    tick();
    chk("R3 masked", dout, mdl[6'h12]);
    idle_in(); ce_n = 1; strb_ctrl_n = 0;
    tick();
    chk("R4 deselect", {63'd0, dout_en}, 64'd0);
    idle_in(); ce_n = 1; strb_proc_n = 0;
    tick();
    chk("R3 idle", {63'd0, dout_en}, 64'd0);
    idle_in(); ce_hi = 0; strb_ctrl_n = 0; addr = 6'd9; gwe_n = 0; din = 64'hDEAD;
    tick();
    chk("R5 strobe deselect", {63'd0, dout_en}, 64'd0);
    idle_in();
    proc_read("R5 no write", 6'd9);
    addr = 6'h10; strb_ctrl_n = 0;
    tick(); idle_in();
    ce_hi = 0; ce_lo_n = 1; adv_n = 0;
    tick();
    chk("R5 ignored off strobe", dout, mdl[6'h11]);
    idle_in();
  endtask

  task automatic t_oe();
    proc_read("R10 setup", 6'h13);
    #1 oe_n = 1;
    #1 chk("R10 off", {63'd0, dout_en}, 64'd0);
    oe_n = 0;
    #1 chk("R10 on", {63'd0, dout_en}, 64'd1);
  endtask

  task automatic t_sleep();
    addr = 6'h10; strb_ctrl_n = 0;
    tick(); idle_in();
    sleep = 1;
    #1 chk("R11 async off", {63'd0, dout_en}, 64'd0);
    tick();
    chk("R11 asleep", {63'd0, dout_en}, 64'd0);
    sleep = 0; addr = 6'h10; strb_ctrl_n = 0; gwe_n = 0; din = 64'hBAD0_BAD0;
    tick();
    chk("R12 err1", {63'd0, proto_err}, 64'd1);
    chk("R12 no access", {63'd0, dout_en}, 64'd0);
    tick();
    chk("R12 err2", {63'd0, proto_err}, 64'd1);
    idle_in();
    tick();
    chk("R12 clear", {63'd0, proto_err}, 64'd0);
    proc_read("R11 retained", 6'h10);
  endtask

  initial begin
    idle_in();
    rst_n = 0; sleep = 0; seq_linear = 1; addr = '0; din = '0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();
    t_reset();
    t_writes();
    t_proc_then_write();
    t_bursts();
    t_enables();
    t_oe();
    t_sleep();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule